// File: doc/BRIEF.md
# EPROM Byte Program-and-Verify Sequencer

This controller writes a single byte into a 16K x 8 ultraviolet-erasable EPROM and then reads the same location back to confirm that the write took. The host pulses a start strobe with a 14-bit location and an 8-bit value. The controller then raises busy and works through a fixed sequence.

First it waits for the external high-voltage supply to report that it is good. It then switches the programming rail onto the part and selects the chip. It presents the address and the data, and holds them for a setup window. Next it drives a single programming pulse low on the write strobe, then keeps the data for a hold window. After that it releases its data driver and waits out a bus-float guard. Last, it opens the output enable, waits out the access delay, samples the byte, and returns the part to the inhibit state.

All windows are counted in clock cycles, derived from the clock period given as a parameter. A mismatch between the read-back byte and the written byte raises a sticky error flag. A one-cycle done pulse marks the end of every sequence.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset the device strobes `dev_ce_n`, `dev_oe_n` and `dev_pgm_n` are all high, `vpp_en` and `dq_oe` are low, and `busy`, `done` and `verr` are low.
- R2: A `start` pulse in idle captures `addr_in` and `data_in`, raises `busy` on the next cycle, and places the captured values on `dev_addr` and `dq_out` for the whole sequence. A `start` while `busy` is high is ignored and changes neither the address nor the data on the device side.
- R3: `vpp_en` is never high while `vpp_good` is low. The controller keeps the chip deselected (`dev_ce_n` high) until `vpp_good` is seen high. `dev_pgm_n` is already high in the cycle in which `vpp_en` rises.
- R4: Program mode is `dev_ce_n` low, `dev_oe_n` high, `dq_oe` high, with the strobe `dev_pgm_n` pulsed low. The address, data, data-driver enable, chip enable, output enable and `vpp_en` are stable for at least SETUP_US microseconds (default 2 µs, 500 cycles at 4 ns) before `dev_pgm_n` falls.
- R5: The `dev_pgm_n` low pulse lasts at least 100 µs and at most 200 µs. The default is PULSE_US = 100 µs, or 25000 cycles at 4 ns.
- R6: `dq_oe` and `dq_out` stay unchanged for at least HOLD_US microseconds (default 2 µs) after `dev_pgm_n` rises.
- R7: `dq_oe` is never high while `dev_oe_n` is low. It drops at least FLOAT_NS nanoseconds (default 130 ns, 33 cycles at 4 ns) before `dev_oe_n` falls.
- R8: In verify mode (`dev_ce_n` low, `dev_oe_n` low, `dev_pgm_n` high) the byte on `dq_in` is sampled no earlier than FLOAT_NS after `dev_oe_n` falls. A difference from the captured data sets `verr`.
- R9: `vpp_en` does not change in any cycle in which `dev_ce_n` and `dev_pgm_n` are both low.
- R10: `verr` stays set after a failed compare until the next accepted `start`, which clears it.
- R11: `done` is high for exactly one cycle per sequence. In that cycle `busy` is low, `dev_ce_n` is high and `vpp_en` is low. With `vpp_good` already high, `done` rises 1 + setup + pulse + hold + 2 x float cycles after the start edge (26067 cycles with the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one program-and-verify sequence |
| addr_in | input | 14 | Target byte location |
| data_in | input | 8 | Byte to write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| verr | output | 1 | Sticky read-back mismatch flag |
| vpp_good | input | 1 | External programming supply reports valid |
| vpp_en | output | 1 | Connects the programming rail to the part |
| dev_addr | output | 14 | Device address bus |
| dq_out | output | 8 | Data driven toward the device |
| dq_oe | output | 1 | Tristate enable for `dq_out` |
| dq_in | input | 8 | Data read from the device bus |
| dev_ce_n | output | 1 | Active-low chip enable |
| dev_oe_n | output | 1 | Active-low output enable |
| dev_pgm_n | output | 1 | Active-low program strobe |

## Verification
The embedded assertions watch every cycle for the following:
- contention between the controller's driver and the device's outputs;
- a rail switch during the programming pulse;
- the rail rising while the write strobe is low or the supply is not good;
- a program strobe outside program mode;
- the pulse width and the setup count at the strobe edges;
- the one-cycle done pulse and the set and clear of the error flag.

Only the bench's scenarios can show the following:
- that the byte actually lands at the captured address;
- that a late sample would read an unsettled bus;
- that a start during a sequence leaves the device side alone;
- that the flag survives idle time and is cleared by the next start;
- that the whole sequence has the expected latency.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PWR    = 3'd1,
    ST_SETUP  = 3'd2,
    ST_PULSE  = 3'd3,
    ST_HOLD   = 3'd4,
    ST_TURN   = 3'd5,
    ST_VERIFY = 3'd6
  } seq_state_t;

  // Cycles covering a span in microseconds, rounded up, never below one.
  function automatic int us_to_cycles(input int us, input int period_ps);
    int c;
    c = (us * 1000000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  // Cycles covering a span in nanoseconds, rounded up, never below one.
  function automatic int ns_to_cycles(input int ns, input int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  // Counter width able to hold the value n.
  function automatic int width_for(input int n);
    int w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/eprom_span_timer.sv
module eprom_span_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart)         cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  // Last cycle of a window that is `limit` cycles long.
  assign expired = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/eprom_seq_ctrl.sv
module eprom_seq_ctrl
  import eprom_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SETUP_CYC = 500,
  parameter int PULSE_CYC = 25000,
  parameter int HOLD_CYC  = 500,
  parameter int FLOAT_CYC = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             vpp_good,
  input  logic             expired,
  output logic             restart,
  output logic [CNT_W-1:0] limit,
  output logic             accept,
  output logic             sample,
  output logic             done,
  output logic             busy,
  output logic             ce_n,
  output logic             oe_n,
  output logic             pgm_n,
  output logic             vpp_req,
  output logic             dq_oe
);
  seq_state_t state_q, state_d;
  logic       done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start)    state_d = ST_PWR;
      ST_PWR:    if (vpp_good) state_d = ST_SETUP;
      ST_SETUP:  if (expired)  state_d = ST_PULSE;
      ST_PULSE:  if (expired)  state_d = ST_HOLD;
      ST_HOLD:   if (expired)  state_d = ST_TURN;
      ST_TURN:   if (expired)  state_d = ST_VERIFY;
      ST_VERIFY: if (expired)  state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  // Window length for the state in progress.
  always_comb begin
    unique case (state_q)
      ST_SETUP:          limit = CNT_W'(SETUP_CYC);
      ST_PULSE:          limit = CNT_W'(PULSE_CYC);
      ST_HOLD:           limit = CNT_W'(HOLD_CYC);
      ST_TURN, ST_VERIFY: limit = CNT_W'(FLOAT_CYC);
      default:           limit = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_VERIFY) && expired;
    end
  end

  assign restart = (state_d != state_q);
  assign accept  = (state_q == ST_IDLE) && start;
  assign sample  = (state_q == ST_VERIFY) && expired;
  assign done    = done_q;
  assign busy    = (state_q != ST_IDLE);
  assign ce_n    = (state_q == ST_IDLE) || (state_q == ST_PWR);
  assign oe_n    = (state_q != ST_VERIFY);
  assign pgm_n   = (state_q != ST_PULSE);
  assign vpp_req = !ce_n;
  assign dq_oe   = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && ce_n));
  assert_pgm_in_program_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_n |-> (!ce_n && oe_n && dq_oe));
  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);
endmodule

// File: rtl/eprom_verify_cmp.sv
module eprom_verify_cmp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] wr_data,
  output logic              err_flag
);
  logic mismatch;
  assign mismatch = (rd_data != wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   err_flag <= 1'b0;
    else if (clear)               err_flag <= 1'b0;
    else if (sample && mismatch)  err_flag <= 1'b1;
  end

  assert_err_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && mismatch && !clear) |=> err_flag);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clear) |=> err_flag);
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_seq_pkg::*;
#(
  parameter int ADDR_W        = 14,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int SETUP_US      = 2,
  parameter int PULSE_US      = 100,
  parameter int HOLD_US       = 2,
  parameter int FLOAT_NS      = 130
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              busy,
  output logic              done,
  output logic              verr,
  input  logic              vpp_good,
  output logic              vpp_en,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in,
  output logic              dev_ce_n,
  output logic              dev_oe_n,
  output logic              dev_pgm_n
);
  localparam int SETUP_CYC = us_to_cycles(SETUP_US, CLK_PERIOD_PS);
  localparam int PULSE_CYC = us_to_cycles(PULSE_US, CLK_PERIOD_PS);
  localparam int HOLD_CYC  = us_to_cycles(HOLD_US,  CLK_PERIOD_PS);
  localparam int FLOAT_CYC = ns_to_cycles(FLOAT_NS, CLK_PERIOD_PS);
  localparam int PMIN_CYC  = us_to_cycles(100, CLK_PERIOD_PS);
  localparam int PMAX_CYC  = (200 * 1000000) / CLK_PERIOD_PS;
  localparam int CNT_W     = width_for(PMAX_CYC + 1);

  logic             restart, expired, accept, sample, vpp_req;
  logic [CNT_W-1:0] limit;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  eprom_span_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .limit(limit), .expired(expired)
  );

  eprom_seq_ctrl #(
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .FLOAT_CYC(FLOAT_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vpp_good(vpp_good),
    .expired(expired), .restart(restart), .limit(limit), .accept(accept),
    .sample(sample), .done(done), .busy(busy), .ce_n(dev_ce_n),
    .oe_n(dev_oe_n), .pgm_n(dev_pgm_n), .vpp_req(vpp_req), .dq_oe(dq_oe)
  );

  eprom_verify_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(sample),
    .rd_data(dq_in), .wr_data(data_q), .err_flag(verr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  // Rail request is gated by the supply flag so it falls with the supply.
  assign vpp_en   = vpp_req && vpp_good;
  assign dev_addr = addr_q;
  assign dq_out   = data_q;

  // Assertion-only observers: strobe width and setup age.
  logic [CNT_W-1:0] pgm_low_cnt, setup_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_low_cnt <= '0;
      setup_age   <= '0;
    end else begin
      pgm_low_cnt <= dev_pgm_n ? '0 : pgm_low_cnt + 1'b1;
      if (dev_ce_n || !vpp_en || !dq_oe)  setup_age <= '0;
      else if (setup_age != '1)           setup_age <= setup_age + 1'b1;
    end
  end

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_pgm_n) |-> (pgm_low_cnt >= CNT_W'(PMIN_CYC) && pgm_low_cnt <= CNT_W'(PMAX_CYC)));
  assert_setup_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_pgm_n) |-> (setup_age >= CNT_W'(SETUP_CYC)));
  assert_rail_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_en) |-> (dev_pgm_n && vpp_good));
  assert_rail_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_ce_n && !dev_pgm_n && $past(!dev_ce_n && !dev_pgm_n) && $stable(vpp_good))
      |-> $stable(vpp_en));
endmodule

// File: tb/tb_eprom_prog_seq.sv
module tb_eprom_prog_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [13:0] addr_in = '0;
  logic [7:0]  data_in = '0;
  logic        vpp_good = 1'b1;
  logic [7:0]  dq_in = 8'hFF;
  logic        busy, done, verr, vpp_en, dq_oe, dev_ce_n, dev_oe_n, dev_pgm_n;
  logic [13:0] dev_addr;
  logic [7:0]  dq_out;

  localparam int SETUP_C = 500;
  localparam int PULSE_C = 25000;
  localparam int PMAX_C  = 50000;
  localparam int HOLD_C  = 500;
  localparam int FLOAT_C = 33;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  logic [7:0] mem [int];

  always #2 clk = ~clk;

  eprom_prog_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in), .data_in(data_in),
    .busy(busy), .done(done), .verr(verr), .vpp_good(vpp_good), .vpp_en(vpp_en),
    .dev_addr(dev_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
    .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .dev_pgm_n(dev_pgm_n)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_mem(input int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  function automatic bit exp_mismatch(input logic [7:0] old, input logic [7:0] d);
    return ((old & d) != d);
  endfunction

  // Device model and timing monitor.
  logic [13:0] p_addr;
  logic [7:0]  p_dq;
  logic        p_dqoe = 0, p_ce = 1, p_oe = 1, p_pgm = 1, p_vpp = 0;
  int addr_age = 0, dq_age = 0, ce_age = 0, oe_age = 0, vpp_age = 0;
  int pgm_low = 0, since_rise = 0, dqoe_off = 0, oe_low = 0;
  bit vpp_toggled = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_pgm && !dev_pgm_n) begin
        chk(ce_age >= SETUP_C && !dev_ce_n, "R4 ce setup", ce_age, SETUP_C);
        chk(oe_age >= SETUP_C && dev_oe_n, "R4 oe setup", oe_age, SETUP_C);
        chk(addr_age >= SETUP_C, "R4 addr setup", addr_age, SETUP_C);
        chk(dq_age >= SETUP_C && dq_oe, "R4 data setup", dq_age, SETUP_C);
        chk(vpp_age >= SETUP_C, "R4 vpp setup", vpp_age, SETUP_C);
      end
      if (!p_pgm && dev_pgm_n) begin
        chk(pgm_low >= PULSE_C && pgm_low <= PMAX_C, "R5 pulse width", pgm_low, PULSE_C);
        chk(!vpp_toggled, "R9 rail steady in pulse", vpp_toggled, 0);
        vpp_toggled = 0;
        mem[int'(dev_addr)] = rd_mem(int'(dev_addr)) & dq_out;
      end
      if (!p_ce && !p_pgm && !dev_ce_n && !dev_pgm_n && (vpp_en != p_vpp)) vpp_toggled = 1;
      if (p_dqoe && !dq_oe)
        chk(since_rise >= HOLD_C && dq_age >= HOLD_C, "R6 data hold", since_rise, HOLD_C);
      if (p_oe && !dev_oe_n)
        chk(!dq_oe && dqoe_off >= FLOAT_C, "R7 turnaround", dqoe_off, FLOAT_C);
      if (!p_vpp && vpp_en)
        chk(vpp_good && dev_pgm_n, "R3 rail rise", {vpp_good, dev_pgm_n}, 3);
      if (vpp_en && !vpp_good) chk(0, "R3 rail without supply", vpp_en, 0);
      if (!dev_oe_n && dq_oe) chk(0, "R7 contention", dq_oe, 0);

      addr_age   = (dev_addr != p_addr) ? 1 : addr_age + 1;
      dq_age     = (dq_out != p_dq || dq_oe != p_dqoe) ? 1 : dq_age + 1;
      ce_age     = (dev_ce_n != p_ce) ? 1 : ce_age + 1;
      oe_age     = (dev_oe_n != p_oe) ? 1 : oe_age + 1;
      vpp_age    = vpp_en ? vpp_age + 1 : 0;
      pgm_low    = dev_pgm_n ? 0 : pgm_low + 1;
      since_rise = (!p_pgm && dev_pgm_n) ? 1 : since_rise + 1;
      dqoe_off   = dq_oe ? 0 : dqoe_off + 1;
      oe_low     = (dev_oe_n || dev_ce_n) ? 0 : oe_low + 1;
      dq_in      = (oe_low >= FLOAT_C) ? rd_mem(int'(dev_addr)) : ~rd_mem(int'(dev_addr));
    end
    p_addr = dev_addr; p_dq = dq_out; p_dqoe = dq_oe; p_ce = dev_ce_n;
    p_oe = dev_oe_n; p_pgm = dev_pgm_n; p_vpp = vpp_en;
  end

  task automatic run(input logic [13:0] a, input logic [7:0] d, input int vdelay, input bit poke);
    logic [7:0] old;
    bit e;
    int n;
    old = rd_mem(int'(a));
    e = exp_mismatch(old, d);
    if (vdelay > 0) vpp_good = 1'b0;
    addr_in = a; data_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(verr == 1'b0, "R10 cleared by start", verr, 0);
    chk(dev_addr == a, "R2 address captured", dev_addr, a);
    if (vdelay > 0) begin
      repeat (vdelay) @(negedge clk);
      chk(vpp_en == 1'b0 && dev_ce_n == 1'b1, "R3 wait for supply", {vpp_en, dev_ce_n}, 1);
      vpp_good = 1'b1;
    end
    n = 0;
    while (!done && !finished) begin
      @(negedge clk);
      n++;
      if (poke && n == 1000) begin
        addr_in = a ^ 14'h1; data_in = ~d; start = 1'b1;
      end
      if (poke && n == 1001) start = 1'b0;
      if (n == 1200) begin
        chk(dev_addr == a, "R2 start ignored addr", dev_addr, a);
        chk(dq_out == d && dq_oe, "R2 start ignored data", dq_out, d);
        chk(!dev_ce_n && dev_oe_n && !dev_pgm_n, "R4 program mode",
            {dev_ce_n, dev_oe_n, dev_pgm_n}, 3'b010);
      end
    end
    if (vdelay == 0) chk(n == 26067, "R11 latency", n, 26067);
    chk(!busy && dev_ce_n && !vpp_en && dev_oe_n, "R11 idle at done",
        {busy, dev_ce_n, vpp_en, dev_oe_n}, 4'b0101);
    chk(verr == e, "R8 compare result", verr, e);
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
  endtask

  initial begin
    logic [13:0] ra;
    logic [7:0]  rd0, rd1;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(dev_ce_n && dev_oe_n && dev_pgm_n, "R1 strobes high", {dev_ce_n, dev_oe_n, dev_pgm_n}, 7);
    chk(!vpp_en && !dq_oe && !busy && !done && !verr, "R1 idle outputs",
        {vpp_en, dq_oe, busy, done, verr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(14'h0000, 8'hA5, 0, 1);
    run(14'h3FFF, 8'h00, 0, 0);
    run(14'h0000, 8'hFF, 0, 0);
    repeat (200) @(negedge clk);
    chk(verr == 1'b1, "R10 flag held in idle", verr, 1);
    ra  = 14'($urandom) | 14'h0100;
    rd0 = 8'($urandom);
    rd1 = 8'($urandom) | 8'h81;
    run(ra, rd0, 300, 0);
    run(ra, rd1, 0, 0);
    chk(total >= 12, "R1 check count", total, 12);
    finished = 1;
  end

  initial begin
    while (!finished && cyc < 195000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) chk(0, "R11 watchdog", cyc, 195000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule